// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address for one address-space context. It reads a context table, then up to three levels of translation tables, all held in ordinary memory. It reaches that memory through a single-word request/acknowledge port that is 36 bits wide. Each table word carries a 2-bit type code. The code says whether the word points onward, maps memory, or is unusable. A mapping word can therefore end the walk early and cover a 16 MB or 256 KB region instead of a 4 KB page.

A caller presents the context root, the context number, the address and a write flag, and then pulses the start input. When the walk ends, the block pulses `done_o` and reports four results: the final entry, the physical address, a fault flag, and the level at which the walk stopped. On a successful walk the block marks the mapping word as referenced, and also as modified when the access is a write. It stores the word back to memory only when one of those bits actually changes.

Top module: `ptw_walker`

## Requirements
- R1: The first read goes to the context table root `{ctx_root_i, 8'h00}` plus four times `ctx_i`. If that context word is not a pointer (type 1), the walk ends with `fault_o`=1 and `level_o`=0.
- R2: A pointer word at level L-1 gives a base of `{word[31:4], 8'h00}`. The read at level L goes to that base plus four times an index. The index is VA[31:24] at level 1, VA[23:18] at level 2 and VA[17:12] at level 3.
- R3: Bits 1:0 of a word encode its type: 0 invalid, 1 pointer, 2 mapping, 3 reserved. An invalid or reserved word at level L ends the walk with `fault_o`=1 and `level_o`=L. In that case `pte_o` holds the word read, `paddr_o` is 0, and no memory write occurs.
- R4: A pointer word at level 3 ends the walk with a fault at level 3.
- R5: A mapping word at level 3 gives `paddr_o` = {word[31:8], VA[11:0]} and `level_o`=3.
- R6: A mapping word at level 2 gives `paddr_o` = {word[31:14], VA[17:0]}. At level 1 it gives {word[31:20], VA[23:0]}. `level_o` reports the level.
- R7: On success, `pte_o` is the word read with bit 5 (referenced) set. Bit 6 (modified) is also set when `write_i` was high at start. All other bits are unchanged.
- R8: On success, exactly one memory write goes to the address the mapping word was read from, carrying the updated word, when that word differs from the word read. Otherwise no write occurs.
- R9: While `mem_req_o` is high and `mem_ack_i` is low, the request address, write flag and write data hold steady. Every request address is word aligned.
- R10: `done_o` is a one-cycle pulse. A start pulse that arrives while a walk is in progress is ignored.
- R11: After reset, `mem_req_o`, `done_o` and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (sampled only when idle) |
| write_i | input | 1 | Access is a write (sets modified bit) |
| ctx_root_i | input | 28 | Context table address bits 35:8 |
| ctx_i | input | CTX_W | Context number |
| va_i | input | 32 | Virtual address |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 36 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Request completes this cycle |
| done_o | output | 1 | Walk finished (one-cycle pulse) |
| fault_o | output | 1 | Walk ended on an unusable word |
| level_o | output | 2 | Level where the walk ended (0 = context) |
| pte_o | output | 32 | Final word (updated on success) |
| paddr_o | output | 36 | Translated physical address |

## Verification
Directed walks cover each place a walk can end. These are a mapping word at each of the three levels, each kind of bad word at levels 0 to 3, and a pointer word at level 3. Together they separate the three address compositions and the fault-level reporting. The same 4 KB mapping is then walked repeatedly as a read and as a write. This shows whether the store-back happens only when the referenced or modified bit is newly set. Random chains use random type codes, pointers, context numbers, addresses and acknowledge delays. Each is compared with a bench model of the walk, which exposes wrong index fields, base shifts or handshake slips. One walk receives a second start pulse mid-flight, to show that the pulse is ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int PA_W   = 36;
    localparam int VA_W   = 32;
    localparam int ENT_W  = 32;
    localparam int L1_LSB = 24;
    localparam int L1_BITS = 8;
    localparam int L2_LSB = 18;
    localparam int L2_BITS = 6;
    localparam int L3_LSB = 12;
    localparam int L3_BITS = 6;
    localparam int REF_BIT = 5;
    localparam int MOD_BIT = 6;

    typedef enum logic [1:0] {
        ET_INVALID = 2'd0,
        ET_POINTER = 2'd1,
        ET_MAPPING = 2'd2,
        ET_RESERVED = 2'd3
    } ent_type_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2
    } walk_state_e;
endpackage

// File: rtl/ptw_index.sv
module ptw_index
    import ptw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic [1:0]            lvl_i,
    input  logic [PA_W-1:0]       base_i,
    input  logic [VA_W-1:L3_LSB]  vpn_i,
    input  logic [CTX_W-1:0]      ctx_i,
    output logic [PA_W-1:0]       addr_o
);
    logic [PA_W-1:0] slot;

    always_comb begin
        case (lvl_i)
            2'd0:    slot = PA_W'(ctx_i);
            2'd1:    slot = PA_W'(vpn_i[L1_LSB +: L1_BITS]);
            2'd2:    slot = PA_W'(vpn_i[L2_LSB +: L2_BITS]);
            default: slot = PA_W'(vpn_i[L3_LSB +: L3_BITS]);
        endcase
        addr_o = base_i + (slot << 2);
    end
endmodule

// File: rtl/ptw_compose.sv
module ptw_compose
    import ptw_pkg::*;
(
    input  logic [1:0]        lvl_i,
    input  logic [ENT_W-1:8]  frame_i,
    input  logic [VA_W-1:0]   va_i,
    output logic [PA_W-1:0]   paddr_o
);
    logic [PA_W-1:0] keep_va;
    logic [PA_W-1:0] frame_pa;
    int unsigned     shamt;

    always_comb begin
        case (lvl_i)
            2'd1:    shamt = L1_LSB;
            2'd2:    shamt = L2_LSB;
            default: shamt = L3_LSB;
        endcase
        keep_va  = (PA_W'(1) << shamt) - PA_W'(1);
        frame_pa = {frame_i, 12'h000};
        paddr_o  = (frame_pa & ~keep_va) | (PA_W'(va_i) & keep_va);
    end
endmodule

// File: rtl/ptw_update.sv
module ptw_update
    import ptw_pkg::*;
(
    input  logic [ENT_W-1:0] ent_i,
    input  logic             write_i,
    output logic [ENT_W-1:0] ent_o,
    output logic             changed_o
);
    always_comb begin
        ent_o          = ent_i;
        ent_o[REF_BIT] = 1'b1;
        if (write_i) begin
            ent_o[MOD_BIT] = 1'b1;
        end
        changed_o = (ent_o != ent_i);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             write_i,
    input  logic [27:0]      ctx_root_i,
    input  logic [CTX_W-1:0] ctx_i,
    input  logic [31:0]      va_i,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [35:0]      mem_addr_o,
    output logic [31:0]      mem_wdata_o,
    input  logic [31:0]      mem_rdata_i,
    input  logic             mem_ack_i,
    output logic             done_o,
    output logic             fault_o,
    output logic [1:0]       level_o,
    output logic [31:0]      pte_o,
    output logic [35:0]      paddr_o
);
    localparam int LAST_LVL = 3;

    typedef struct packed {
        walk_state_e       st;
        logic [1:0]        lvl;
        logic [VA_W-1:0]   va;
        logic [CTX_W-1:0]  ctx;
        logic              wr;
        logic [PA_W-1:0]   addr;
        logic [ENT_W-1:0]  wdata;
        logic              done;
        logic              fault;
        logic [1:0]        rlvl;
        logic [ENT_W-1:0]  pte;
        logic [PA_W-1:0]   paddr;
    } walk_regs_t;

    walk_regs_t q, d;

    logic [1:0]       ix_lvl;
    logic [PA_W-1:0]  ix_base;
    logic [VA_W-1:0]  ix_va;
    logic [CTX_W-1:0] ix_ctx;
    logic [PA_W-1:0]  ix_addr;
    logic [PA_W-1:0]  map_pa;
    logic [ENT_W-1:0] upd_ent;
    logic             upd_changed;
    ent_type_e        etype;

    assign etype = ent_type_e'(mem_rdata_i[1:0]);

    always_comb begin
        if (q.st == S_IDLE) begin
            ix_lvl  = 2'd0;
            ix_base = {ctx_root_i, 8'h00};
            ix_va   = va_i;
            ix_ctx  = ctx_i;
        end else begin
            ix_lvl  = q.lvl + 2'd1;
            ix_base = {mem_rdata_i[ENT_W-1:4], 8'h00};
            ix_va   = q.va;
            ix_ctx  = q.ctx;
        end
    end

    ptw_index #(.CTX_W(CTX_W)) u_index (
        .lvl_i  (ix_lvl),
        .base_i (ix_base),
        .vpn_i  (ix_va[VA_W-1:L3_LSB]),
        .ctx_i  (ix_ctx),
        .addr_o (ix_addr)
    );

    ptw_compose u_compose (
        .lvl_i   (q.lvl),
        .frame_i (mem_rdata_i[ENT_W-1:8]),
        .va_i    (q.va),
        .paddr_o (map_pa)
    );

    ptw_update u_update (
        .ent_i     (mem_rdata_i),
        .write_i   (q.wr),
        .ent_o     (upd_ent),
        .changed_o (upd_changed)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.st   = S_READ;
                    d.lvl  = 2'd0;
                    d.va   = va_i;
                    d.ctx  = ctx_i;
                    d.wr   = write_i;
                    d.addr = ix_addr;
                end
            end
            S_READ: begin
                if (mem_ack_i) begin
                    if (etype == ET_POINTER && q.lvl != 2'(LAST_LVL)) begin
                        d.lvl  = q.lvl + 2'd1;
                        d.addr = ix_addr;
                    end else if (etype == ET_MAPPING && q.lvl != 2'd0) begin
                        d.fault = 1'b0;
                        d.rlvl  = q.lvl;
                        d.pte   = upd_ent;
                        d.paddr = map_pa;
                        if (upd_changed) begin
                            d.st    = S_WRITE;
                            d.wdata = upd_ent;
                        end else begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                        end
                    end else begin
                        d.st    = S_IDLE;
                        d.done  = 1'b1;
                        d.fault = 1'b1;
                        d.rlvl  = q.lvl;
                        d.pte   = mem_rdata_i;
                        d.paddr = '0;
                    end
                end
            end
            S_WRITE: begin
                if (mem_ack_i) begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_req_o   = (q.st != S_IDLE);
    assign mem_we_o    = (q.st == S_WRITE);
    assign mem_addr_o  = q.addr;
    assign mem_wdata_o = q.wdata;
    assign done_o      = q.done;
    assign fault_o     = q.fault;
    assign level_o     = q.rlvl;
    assign pte_o       = q.pte;
    assign paddr_o     = q.paddr;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req_o,
    input logic        mem_we_o,
    input logic [35:0] mem_addr_o,
    input logic [31:0] mem_wdata_o,
    input logic        mem_ack_i,
    input logic        done_o,
    input logic        fault_o,
    input logic [31:0] pte_o,
    input logic [35:0] paddr_o
);
    // R9: an outstanding request does not move
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o));

    assert_addr_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> mem_addr_o[1:0] == 2'b00);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o);

    assert_success_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !fault_o |-> pte_o[5] && pte_o[1:0] == 2'b10);

    assert_store_mapping_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o |-> mem_wdata_o[5] && mem_wdata_o[1:0] == 2'b10);

    assert_fault_no_pa_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && fault_o |-> paddr_o == 36'h0);
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .pte_o       (pte_o),
    .paddr_o     (paddr_o)
);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr = 1'b0;
    logic [27:0] root = '0;
    logic [7:0]  ctx = '0;
    logic [31:0] va = '0;
    logic        mem_req, mem_we, mem_ack, done, fault;
    logic [35:0] mem_addr, paddr;
    logic [31:0] mem_wdata, mem_rdata, pte;
    logic [1:0]  level;

    logic [31:0] mem [bit [35:0]];
    int n_chk = 0;
    int n_err = 0;
    int wr_cnt = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk(clk), .rst_n(rst_n), .start_i(start), .write_i(wr),
        .ctx_root_i(root), .ctx_i(ctx), .va_i(va),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
        .done_o(done), .fault_o(fault), .level_o(level), .pte_o(pte),
        .paddr_o(paddr)
    );

    function automatic logic [31:0] rd(input logic [35:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory responder with random acknowledge delay
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req && ($urandom % 3 != 0)) begin
            mem_ack   <= 1'b1;
            mem_rdata <= rd(mem_addr);
            if (mem_addr[1:0] != 2'b00) begin
                n_err++;
                $display("FAIL R9: actual=%0h expected=aligned", mem_addr);
            end
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_cnt++;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_err++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input logic [1:0] t, input logic [35:0] nb,
                                       input logic [31:0] mapw);
        case (t)
            2'd1:    return {nb[35:8], 2'b00, 2'b01};
            2'd2:    return {mapw[31:2], 2'b10};
            default: return {$urandom() & 32'hFFFF_FFFC} | {30'h0, t};
        endcase
    endfunction

    // lay a chain of words along the path of one walk
    task automatic build(input logic [27:0] rt, input logic [7:0] c, input logic [31:0] v,
                         input logic [1:0] t0, input logic [1:0] t1, input logic [1:0] t2,
                         input logic [1:0] t3, input logic [31:0] mapw);
        logic [35:0] b, nb;
        logic [1:0]  ts [4];
        logic [35:0] a;
        ts[0] = t0; ts[1] = t1; ts[2] = t2; ts[3] = t3;
        b = {rt, 8'h00};
        for (int l = 0; l < 4; l++) begin
            case (l)
                0: a = b + {26'h0, c, 2'b00};
                1: a = b + {26'h0, v[31:24], 2'b00};
                2: a = b + {28'h0, v[23:18], 2'b00};
                default: a = b + {28'h0, v[17:12], 2'b00};
            endcase
            nb = {$urandom(), 4'h0} & 36'hF_FFFF_FC00;
            mem[a] = mk(ts[l], nb, mapw);
            if (ts[l] != 2'd1) break;
            b = nb;
        end
    endtask

    task automatic model(input logic [27:0] rt, input logic [7:0] c, input logic [31:0] v,
                         input logic w, output logic ef, output logic [1:0] el,
                         output logic [31:0] ep, output logic [35:0] ea,
                         output logic ewb, output logic [35:0] eaddr, output string ftag);
        logic [35:0] b, a;
        logic [31:0] e;
        b = {rt, 8'h00};
        ef = 1'b1; ewb = 1'b0; ea = '0; el = 2'd0; ep = '0; eaddr = '0; ftag = "R1";
        for (int l = 0; l < 4; l++) begin
            case (l)
                0: a = b + {26'h0, c, 2'b00};
                1: a = b + {26'h0, v[31:24], 2'b00};
                2: a = b + {28'h0, v[23:18], 2'b00};
                default: a = b + {28'h0, v[17:12], 2'b00};
            endcase
            e = rd(a);
            el = 2'(l);
            if (e[1:0] == 2'd1 && l < 3) begin
                b = {e[31:4], 8'h00};
                continue;
            end
            if (e[1:0] == 2'd2 && l > 0) begin
                ef = 1'b0;
                ep = e | 32'h20 | (w ? 32'h40 : 32'h0);
                ewb = (ep != e);
                eaddr = a;
                case (l)
                    1: ea = {e[31:20], v[23:0]};
                    2: ea = {e[31:14], v[17:0]};
                    default: ea = {e[31:8], v[11:0]};
                endcase
                ftag = (l == 3) ? "R5" : "R6";
            end else begin
                ep = e;
                ftag = (l == 0) ? "R1" : ((l == 3 && e[1:0] == 2'd1) ? "R4" : "R3");
            end
            break;
        end
    endtask

    task automatic run(input logic [27:0] rt, input logic [7:0] c, input logic [31:0] v,
                       input logic w, input bit poke);
        logic ef, ewb;
        logic [1:0] el;
        logic [31:0] ep;
        logic [35:0] ea, eaddr;
        string ft;
        int n;
        model(rt, c, v, w, ef, el, ep, ea, ewb, eaddr, ft);
        @(negedge clk);
        root = rt; ctx = c; va = v; wr = w; start = 1'b1; wr_cnt = 0;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            start = 1'b1; va = ~v; ctx = ~c; wr = ~w;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk("R10 done seen", 64'(done), 64'(1));
        chk({ft, " fault"}, 64'(fault), 64'(ef));
        chk({ft, " R2 level"}, 64'(level), 64'(el));
        chk({ft, " R7 pte"}, 64'(pte), 64'(ep));
        chk({ft, " paddr"}, 64'(paddr), 64'(ea));
        chk("R8 write count", 64'(wr_cnt), 64'(ewb));
        if (ewb) chk("R8 stored word", 64'(rd(eaddr)), 64'(ep));
        @(negedge clk);
        chk("R10 done pulse", 64'(done), 64'(0));
        if (poke) begin
            repeat (12) @(negedge clk);
            chk("R10 ignored start", 64'({mem_req, done}), 64'(0));
        end
    endtask

    initial begin
        logic [27:0] rt;
        logic [31:0] v;
        logic [7:0]  c;
        void'($urandom(32'd7041));
        repeat (3) @(negedge clk);
        chk("R11 req", 64'(mem_req), 64'(0));
        chk("R11 done", 64'(done), 64'(0));
        chk("R11 fault", 64'(fault), 64'(0));
        rst_n = 1'b1;

        rt = 28'h012_3450; c = 8'h05; v = 32'hA5C3_7123;
        // R5 R7 R8: level 3 mapping, referenced clear, read access
        build(rt, c, v, 1, 1, 1, 2, 32'hBEEF_1A82 & ~32'h60);
        run(rt, c, v, 1'b0, 1'b0);
        run(rt, c, v, 1'b0, 1'b0);      // R8 already referenced: no store
        run(rt, c, v, 1'b1, 1'b0);      // R7 write sets modified
        run(rt, c, v, 1'b1, 1'b0);      // R8 nothing changes
        build(rt, c, v, 1, 1, 2, 0, 32'h1357_9BDE);   // R6 level 2
        run(rt, c, v, 1'b1, 1'b0);
        build(rt, c, v, 1, 2, 0, 0, 32'h2468_ACE2);   // R6 level 1
        run(rt, c, v, 1'b0, 1'b0);
        build(rt, c, v, 0, 0, 0, 0, 0); run(rt, c, v, 1'b0, 1'b0); // R1
        build(rt, c, v, 2, 0, 0, 0, 0); run(rt, c, v, 1'b0, 1'b0); // R1
        build(rt, c, v, 1, 0, 0, 0, 0); run(rt, c, v, 1'b0, 1'b0); // R3
        build(rt, c, v, 1, 1, 3, 0, 0); run(rt, c, v, 1'b1, 1'b0); // R3
        build(rt, c, v, 1, 1, 1, 0, 0); run(rt, c, v, 1'b0, 1'b0); // R3
        build(rt, c, v, 1, 1, 1, 1, 0); run(rt, c, v, 1'b0, 1'b0); // R4
        build(rt, c, v, 1, 1, 1, 2, 32'h0F0F_0F02);
        run(rt, c, v, 1'b0, 1'b1);      // R10 start while busy

        for (int i = 0; i < 300; i++) begin
            logic [1:0] ts [4];
            mem.delete();
            rt = 28'($urandom());
            c = 8'($urandom());
            v = $urandom();
            for (int k = 0; k < 4; k++) ts[k] = ($urandom % 4 == 0) ? 2'($urandom()) : 2'(1);
            if ($urandom % 2 == 1) ts[1 + ($urandom % 3)] = 2'd2;
            build(rt, c, v, ts[0], ts[1], ts[2], ts[3], $urandom());
            run(rt, c, v, 1'($urandom()), 1'b0);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule